// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for the host-facing side of a serial keyboard. It keeps a small circular queue of bytes that the host drains through a read port, and it fills that queue from two sources. The first is a decoder for command bytes sent by the host. An identify command and a layout query each empty the queue and then load a fixed reply. A set-indicator command swallows the byte that follows it. The second source is a key-event encoder. It turns an already-mapped scan code plus a down/up flag into one queue byte. For the two toggling lock keys it drops alternate edges, so one physical toggle yields exactly one press byte and one release byte.

A reply is written one byte per clock. While a reply is being written, `cmd_busy` is high. During that time the block ignores both command bytes and key events, and the source must hold them back. Reads are registered: the byte requested by `rd_en` appears on `rd_data` one clock later.

Top module: `kbd_responder`

## Requirements
- R1: After synchronous reset `q_not_empty`, `cmd_busy` and `rd_data` are 0, the indicator-swallow flag is clear and both lock modes are 0.
- R2: An accepted command 0x01 empties the queue at its clock edge. It then writes 0xFF, 0x04 and 0x7F on the next three edges, with `cmd_busy` high for exactly those three cycles.
- R3: An accepted command 0x07 or 0x0F empties the queue and then writes 0xFE and 0x21 on the next two edges, with `cmd_busy` high for two cycles.
- R4: Command 0x0E writes nothing and arms a swallow flag. The next accepted command byte, whatever its value, has no effect except clearing that flag.
- R5: Any other command byte leaves the queue unchanged and `cmd_busy` low.
- R6: While `cmd_busy` is high, `cmd_valid` and `key_valid` have no effect.
- R7: A key event with neither lock flag writes `key_code` when `key_down` is 1. When `key_down` is 0 it writes `key_code` with bit 7 forced to 1.
- R8: Each lock key (`key_caps`, which wins over `key_num`) keeps a 2-bit mode. A press XORs it with 1 and is dropped if the result is 2. A release XORs it with 2 and is dropped if the result is 3. The mode updates even when the byte is dropped.
- R9: The queue returns bytes in write order, holds `DEPTH` (default 16) bytes, and discards a write that arrives when it is full. Full is judged before any read in the same cycle.
- R10: `rd_en` on an empty queue makes `rd_data` 0 on the next cycle. A read on a non-empty queue shows the oldest byte on the next cycle.
- R11: When a key event and an emptying command are accepted in the same cycle, the emptying wins: the key byte is lost, but its lock-mode update is kept. A read in that cycle still returns the old oldest byte. A read and a write in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte from the host |
| cmd_busy | output | 1 | Reply in progress; commands and keys ignored |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 8 | Mapped scan code |
| key_down | input | 1 | 1 = press, 0 = release |
| key_caps | input | 1 | Event is the caps-lock key |
| key_num | input | 1 | Event is the num-lock key |
| rd_en | input | 1 | Pop the oldest queue byte |
| rd_data | output | 8 | Byte read, valid the cycle after `rd_en` |
| q_not_empty | output | 1 | Queue holds at least one byte |

## Verification
Two functions can meet in the same cycle. A key event can arrive on the same edge that a queue-emptying command is accepted, and a host read can land on that edge or on any write. The bench drives key and command strobes together on purpose, and it also drives reads alongside writes in directed steps and in a long seeded random run. A reference model judges each case from the stated order: the oldest byte is read first, a write into a full queue is dropped, and emptying the queue beats a key write while the key's lock mode still advances.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;

  localparam logic [7:0] CMD_IDENT    = 8'h01;
  localparam logic [7:0] CMD_INDIC    = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;
  localparam logic [7:0] RELEASE_MASK = 8'h80;
  localparam int         NUM_LOCKS    = 2;

  typedef enum logic [1:0] {
    RPL_NONE   = 2'd0,
    RPL_IDENT  = 2'd1,
    RPL_LAYOUT = 2'd2
  } reply_e;

  function automatic logic [7:0] reply_byte(reply_e kind, logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    case (kind)
      RPL_IDENT: begin
        case (idx)
          2'd0:    b = 8'hFF;
          2'd1:    b = 8'h04;
          default: b = 8'h7F;
        endcase
      end
      RPL_LAYOUT: b = (idx == 2'd0) ? 8'hFE : 8'h21;
      default:    b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             full, empty, wr_ok, rd_ok;

  assign full  = (count == FULLC);
  assign empty = (count == '0);
  assign wr_ok = push && !full && !flush;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= empty ? '0 : mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_empty = !empty;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULLC) else $error("count over depth"); // R9

  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    full && push && !rd_en && !flush |=> count == FULLC && $stable(wptr)) else $error("write into full queue"); // R9

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && empty |=> rd_data == '0) else $error("empty read not zero"); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !not_empty) else $error("flush left bytes"); // R11

endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       busy,
  output logic       flush,
  output logic       push,
  output logic [7:0] push_data
);
  reply_e     kind;
  logic [1:0] left;
  logic [1:0] idx;
  logic       led_armed;
  logic       accept, is_ident, is_layout;

  assign busy      = (left != 2'd0);
  assign accept    = cmd_valid && !busy;
  assign is_ident  = (cmd_byte == CMD_IDENT);
  assign is_layout = (cmd_byte == CMD_LAYOUT_A) || (cmd_byte == CMD_LAYOUT_B);
  assign flush     = accept && !led_armed && (is_ident || is_layout);
  assign push      = busy;
  assign push_data = reply_byte(kind, idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind      <= RPL_NONE;
      left      <= 2'd0;
      idx       <= 2'd0;
      led_armed <= 1'b0;
    end else if (busy) begin
      left <= left - 2'd1;
      idx  <= idx + 2'd1;
    end else if (accept) begin
      if (led_armed) begin
        led_armed <= 1'b0;
      end else if (is_ident) begin
        kind <= RPL_IDENT;
        left <= 2'd3;
        idx  <= 2'd0;
      end else if (is_layout) begin
        kind <= RPL_LAYOUT;
        left <= 2'd2;
        idx  <= 2'd0;
      end else if (cmd_byte == CMD_INDIC) begin
        led_armed <= 1'b1;
      end
    end
  end

  AST_LED_SWALLOW: assert property (@(posedge clk) disable iff (rst)
    led_armed && accept |=> !led_armed && !busy) else $error("swallow failed"); // R4

  AST_REPLY_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    busy |=> left == $past(left) - 2'd1) else $error("reply stalled"); // R2

  AST_BUSY_HOLDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> $stable(led_armed)) else $error("command taken while busy"); // R6

endmodule

// File: rtl/kbd_key_encoder.sv
module kbd_key_encoder
  import kbd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       key_down,
  input  logic       key_caps,
  input  logic       key_num,
  output logic       push,
  output logic [7:0] push_data
);
  logic [NUM_LOCKS-1:0] req, hit;
  logic [1:0]           mode [NUM_LOCKS];
  logic [1:0]           cur, nxt;
  logic                 is_lock, drop;

  assign req = {key_num, key_caps};

  always_comb begin
    hit = '0;
    cur = 2'd0;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      if (req[i] && hit == '0) begin
        hit[i] = 1'b1;
        cur    = mode[i];
      end
    end
  end

  assign is_lock   = |req;
  assign nxt       = key_down ? (cur ^ 2'd1) : (cur ^ 2'd2);
  assign drop      = is_lock && (key_down ? (nxt == 2'd2) : (nxt == 2'd3));
  assign push      = key_valid && !drop;
  assign push_data = key_down ? key_code : (key_code | RELEASE_MASK);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst) begin
        mode[g] <= 2'd0;
      end else if (key_valid && hit[g]) begin
        mode[g] <= nxt;
      end
    end
  end

  AST_LOCK_FIRST_PRESS: assert property (@(posedge clk) disable iff (rst)
    key_valid && is_lock && key_down && cur == 2'd0 |-> push) else $error("first lock press lost"); // R8

endmodule

// File: rtl/kbd_responder.sv
module kbd_responder #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       cmd_busy,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       key_down,
  input  logic       key_caps,
  input  logic       key_num,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       q_not_empty
);
  logic       seq_flush, seq_push, key_push, key_go;
  logic [7:0] seq_data, key_data;
  logic       q_push;
  logic [7:0] q_data;

  kbd_cmd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .busy      (cmd_busy),
    .flush     (seq_flush),
    .push      (seq_push),
    .push_data (seq_data)
  );

  assign key_go = key_valid && !cmd_busy;

  kbd_key_encoder u_key (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_go),
    .key_code  (key_code),
    .key_down  (key_down),
    .key_caps  (key_caps),
    .key_num   (key_num),
    .push      (key_push),
    .push_data (key_data)
  );

  assign q_push = seq_push || key_push;
  assign q_data = seq_push ? seq_data : key_data;

  kbd_byte_queue #(.DEPTH(DEPTH), .WIDTH(8)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .flush     (seq_flush),
    .push      (q_push),
    .push_data (q_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .not_empty (q_not_empty)
  );

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(seq_push && key_push)) else $error("two queue writers"); // R6

endmodule

// File: tb/kbd_responder_tb.sv
`timescale 1ns/1ps
module kbd_responder_tb;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, key_valid, key_down, key_caps, key_num, rd_en;
  logic [7:0] cmd_byte, key_code;
  logic cmd_busy, q_not_empty;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  kbd_responder #(.DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_busy(cmd_busy), .key_valid(key_valid), .key_code(key_code),
    .key_down(key_down), .key_caps(key_caps), .key_num(key_num),
    .rd_en(rd_en), .rd_data(rd_data), .q_not_empty(q_not_empty)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mq [D];
  int mh, mc, rl, ri;
  logic [7:0] rcmd, exp_rd;
  bit led;
  logic [1:0] mcaps, mnum;

  function automatic int reply_len(logic [7:0] c);
    if (c == 8'h01) return 3;
    if (c == 8'h07 || c == 8'h0F) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] reply_at(logic [7:0] c, int i);
    if (c == 8'h01) return (i == 0) ? 8'hFF : (i == 1) ? 8'h04 : 8'h7F;
    return (i == 0) ? 8'hFE : 8'h21;
  endfunction

  task automatic model_reset();
    mh = 0; mc = 0; rl = 0; ri = 0; rcmd = 0; exp_rd = 0;
    led = 0; mcaps = 0; mnum = 0;
  endtask

  task automatic model_edge(bit cv, logic [7:0] cb, bit kv, logic [7:0] kc,
                            bit kd, bit kcap, bit knum, bit re);
    int pre_c, old_h;
    bit do_push, flush, drop;
    logic [7:0] pb;
    logic [1:0] m;
    pre_c = mc; old_h = mh;
    do_push = 0; flush = 0; pb = 0;
    if (re) exp_rd = (pre_c > 0) ? mq[mh] : 8'h00;
    if (rl > 0) begin
      pb = reply_at(rcmd, ri); do_push = 1; ri++; rl--;
    end else begin
      if (kv) begin
        drop = 0;
        if (kcap || knum) begin
          m = kcap ? mcaps : mnum;
          m = kd ? (m ^ 2'd1) : (m ^ 2'd2);
          drop = kd ? (m == 2'd2) : (m == 2'd3);
          if (kcap) mcaps = m; else mnum = m;
        end
        if (!drop) begin
          do_push = 1; pb = kd ? kc : (kc | 8'h80);
        end
      end
      if (cv) begin
        if (led) led = 0;
        else if (reply_len(cb) > 0) begin
          flush = 1; rcmd = cb; rl = reply_len(cb); ri = 0;
        end else if (cb == 8'h0E) led = 1;
      end
    end
    if (re && pre_c > 0) begin mh = (mh + 1) % D; mc--; end
    if (do_push && pre_c < D) begin mq[(old_h + pre_c) % D] = pb; mc++; end
    if (flush) begin mh = 0; mc = 0; end
  endtask

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit cv, logic [7:0] cb, bit kv, logic [7:0] kc,
                      bit kd, bit kcap, bit knum, bit re);
    @(negedge clk);
    cmd_valid = cv; cmd_byte = cb; key_valid = kv; key_code = kc;
    key_down = kd; key_caps = kcap; key_num = knum; rd_en = re;
    @(posedge clk);
    model_edge(cv, cb, kv, kc, kd, kcap, knum, re);
    #1;
    check(tag, "busy", {7'd0, cmd_busy}, {7'd0, rl > 0});
    check(tag, "not_empty", {7'd0, q_not_empty}, {7'd0, mc > 0});
    check(tag, "rd_data", rd_data, exp_rd);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0);
  endtask
  task automatic cmd(string tag, logic [7:0] b);
    step(tag, 1, b, 0, 8'h00, 0, 0, 0, 0);
  endtask
  task automatic key(string tag, logic [7:0] c, bit d, bit cp, bit nm);
    step(tag, 0, 8'h00, 1, c, d, cp, nm, 0);
  endtask
  task automatic rd(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 0, 8'h00, 0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    cmd_valid = 0; cmd_byte = 0; key_valid = 0; key_code = 0;
    key_down = 0; key_caps = 0; key_num = 0; rd_en = 0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle("R1", 2);
    rd("R1", 1);

    // R2 identify reply, then over-read gives zero (R10)
    key("R2", 8'h31, 1, 0, 0);
    cmd("R2", 8'h01);
    idle("R2", 3);
    rd("R2", 3);
    rd("R10", 2);

    // R3 layout queries
    cmd("R3", 8'h07); idle("R3", 2); rd("R3", 2);
    cmd("R3", 8'h0F); idle("R3", 2); rd("R3", 3);

    // R4 swallow flag: the identify after 0x0E must do nothing
    cmd("R4", 8'h0E); cmd("R4", 8'h01); idle("R4", 3);
    cmd("R4", 8'h07); idle("R4", 2); rd("R4", 3);

    // R5 other command bytes
    key("R5", 8'h22, 1, 0, 0);
    cmd("R5", 8'h05); cmd("R5", 8'h00); cmd("R5", 8'hFF); cmd("R5", 8'h02);
    rd("R5", 2);

    // R6 commands and keys while busy
    cmd("R6", 8'h01);
    cmd("R6", 8'h07);
    key("R6", 8'h44, 1, 0, 0);
    cmd("R6", 8'h0E);
    idle("R6", 1);
    rd("R6", 4);
    cmd("R6", 8'h05);

    // R7 plain press and release
    key("R7", 8'h1C, 1, 0, 0); key("R7", 8'h1C, 0, 0, 0);
    key("R7", 8'h7F, 0, 0, 0); key("R7", 8'hA5, 1, 0, 0);
    rd("R7", 5);

    // R8 lock keys: two toggles each, interleaved, caps beats num
    for (int t = 0; t < 2; t++) begin
      key("R8", 8'h77, 1, 1, 0); key("R8", 8'h62, 1, 0, 1);
      key("R8", 8'h77, 0, 1, 0); key("R8", 8'h62, 0, 0, 1);
    end
    key("R8", 8'h77, 1, 1, 1); key("R8", 8'h77, 0, 1, 1);
    rd("R8", 10);

    // R9 fill beyond depth, then drain
    for (int i = 0; i < D + 4; i++) key("R9", 8'(i + 1), 1, 0, 0);
    step("R9", 0, 8'h00, 1, 8'h55, 1, 0, 0, 1);
    rd("R9", D + 2);

    // R11 key with flushing command in the same cycle, read with it
    key("R11", 8'h10, 1, 0, 0);
    step("R11", 1, 8'h01, 1, 8'h77, 1, 1, 0, 1);
    idle("R11", 3);
    step("R11", 0, 8'h00, 1, 8'h77, 0, 1, 0, 1);
    rd("R11", 4);
    step("R11", 0, 8'h00, 1, 8'h3A, 1, 0, 0, 1);
    rd("R11", 2);

    // seeded random mix (R9 ordering and R11 overlaps)
    for (int n = 0; n < 4000; n++) begin
      bit cv, kv, re, kd, kcap, knum;
      logic [7:0] cb, kc;
      int r;
      r = $urandom_range(0, 99);
      cv = (r < 8);
      case ($urandom_range(0, 5))
        0: cb = 8'h01; 1: cb = 8'h07; 2: cb = 8'h0F;
        3: cb = 8'h0E; default: cb = 8'($urandom_range(0, 255));
      endcase
      kv = ($urandom_range(0, 99) < 45);
      kc = 8'($urandom_range(0, 255));
      kd = $urandom_range(0, 1) == 1;
      r = $urandom_range(0, 9);
      kcap = (r == 0); knum = (r == 1) || (r == 2);
      re = ($urandom_range(0, 99) < 40);
      step("R9", cv, cb, kv, kc, kd, kcap, knum, re);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule